// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects up to 32 hardware event lines into a latched cause register and presents them to software through a small word-addressed register port. Software picks, bit by bit, whether a latched cause is removed by writing a one to it or by reading it. It can also force cause bits from software and mask or unmask individual sources. A dedicated set alias and clear alias let it change single mask bits without a read-modify-write.

The visible pending set is the cause ANDed with the inverted mask. Its OR-reduction, taken from a flip-flop, is the single interrupt request. The bank is meant to sit behind a simple memory-mapped read/write port. Word addresses are fixed: 0 clear-mode control, 1 cause, 2 masked cause, 3 cause force (write-only), 4 mask, 5 mask-set alias, 6 mask-clear alias, 7 unused.

Top module: `irq_bank_top`

## Requirements
- R1: After reset, the control, cause and mask registers all hold zero and the interrupt request is low. Every source therefore starts unmasked and in write-one-to-clear mode.
- R2: An event input that is high at a clock edge sets its cause bit at that edge. The bit then stays set until it is cleared.
- R3: A control bit of 0 selects write-one-to-clear. Writing a 1 to word 1 clears the matching cause bit, and so does writing a 1 to word 2 for a bit that is unmasked. Cause bits whose control bit is 1 ignore these writes.
- R4: A control bit of 1 selects clear-on-read. A read of word 1 clears those cause bits at the end of the read cycle. A read of word 2 clears only those that are unmasked. Reads never clear a bit whose control bit is 0.
- R5: When a set source (event input or cause force) and a clear (write or read) hit the same bit in one cycle, the bit ends up set. On a clear-on-read bit the read still returns 1.
- R6: Writing to word 3 sets every cause bit where the write data has a 1, and leaves the other bits unchanged.
- R7: Word 4 holds the mask and can be read and written directly. Writing word 5 sets the mask bits where the data has a 1. Writing word 6 clears the mask bits where the data has a 1. Zero bits leave the mask unchanged.
- R8: Word 2 reads as cause AND NOT mask.
- R9: The interrupt request is a register. After each clock edge it equals the OR of (cause AND NOT mask) as it stands after that edge.
- R10: Read data is combinational and is zero unless read enable is high. Words 3, 5, 6 and 7 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Word address |
| regWe | input | 1 | Write enable |
| regWdata | input | 32 | Write data |
| regRe | input | 1 | Read enable; clear-on-read bits clear at the edge that ends the read |
| regRdata | output | 32 | Read data, valid in the cycle of regRe |
| evtIn | input | 32 | Hardware event lines, one per cause bit |
| irqOut | output | 1 | Registered interrupt request |

## Verification
Setting and clearing can land on the same cause bit in one cycle. An event line may be high during a clear-on-read access to word 1, or during a write-one-to-clear write to the same bit. The bench drives exactly these overlaps. It then checks that the read returned the bit and that a second read still finds it set. A third read, with no event pending, must show the bit finally gone and the interrupt request following it.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  localparam int WORD_ADDR_W = 3;

  typedef enum logic [WORD_ADDR_W-1:0] {
    WORD_CTRL     = 3'd0,
    WORD_CAUSE    = 3'd1,
    WORD_MASKED   = 3'd2,
    WORD_FORCE    = 3'd3,
    WORD_MASK     = 3'd4,
    WORD_MASK_SET = 3'd5,
    WORD_MASK_CLR = 3'd6,
    WORD_SPARE    = 3'd7
  } regWord_e;

  typedef struct packed {
    logic     wrCtrl;
    logic     clrCause;
    logic     clrMasked;
    logic     rdCause;
    logic     rdMasked;
    logic     wrForce;
    logic     wrMask;
    logic     wrMaskSet;
    logic     wrMaskClr;
    logic     rdEn;
    regWord_e rdSel;
  } bankStrobes_t;

endpackage

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [WORD_ADDR_W-1:0] regAddr,
  input  logic                   regWe,
  input  logic                   regRe,
  output bankStrobes_t           strobes
);

  regWord_e word;

  always_comb begin
    word                = regWord_e'(regAddr);
    strobes             = '0;
    strobes.rdEn        = regRe;
    strobes.rdSel       = word;
    strobes.wrCtrl      = regWe && (word == WORD_CTRL);
    strobes.clrCause    = regWe && (word == WORD_CAUSE);
    strobes.clrMasked   = regWe && (word == WORD_MASKED);
    strobes.wrForce     = regWe && (word == WORD_FORCE);
    strobes.wrMask      = regWe && (word == WORD_MASK);
    strobes.wrMaskSet   = regWe && (word == WORD_MASK_SET);
    strobes.wrMaskClr   = regWe && (word == WORD_MASK_CLR);
    strobes.rdCause     = regRe && (word == WORD_CAUSE);
    strobes.rdMasked    = regRe && (word == WORD_MASKED);
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrCtrl, strobes.clrCause, strobes.clrMasked, strobes.wrForce,
              strobes.wrMask, strobes.wrMaskSet, strobes.wrMaskClr})); // R7

  AST_READ_STROBE_NEEDS_RE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdCause || strobes.rdMasked) |-> regRe); // R4

endmodule

// File: rtl/irq_bank_dp.sv
module irq_bank_dp
  import irq_bank_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobes_t      strobes,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] evtIn,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);

  logic [DATA_W-1:0] ctrlQ, causeQ, maskQ;
  logic [DATA_W-1:0] causeNext, maskNext, setVec;
  logic              irqQ;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic clrReq, setReq;
    always_comb begin
      clrReq = (strobes.clrCause  &  regWdata[b] & ~ctrlQ[b])
             | (strobes.clrMasked &  regWdata[b] & ~ctrlQ[b] & ~maskQ[b])
             | (strobes.rdCause   &  ctrlQ[b])
             | (strobes.rdMasked  &  ctrlQ[b] & ~maskQ[b]);
      setReq = evtIn[b] | (strobes.wrForce & regWdata[b]);
      causeNext[b] = setReq | (causeQ[b] & ~clrReq);
      setVec[b]    = setReq;
      if (strobes.wrMask)         maskNext[b] = regWdata[b];
      else if (strobes.wrMaskSet) maskNext[b] = maskQ[b] | regWdata[b];
      else if (strobes.wrMaskClr) maskNext[b] = maskQ[b] & ~regWdata[b];
      else                        maskNext[b] = maskQ[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      causeQ <= '0;
      maskQ  <= '0;
      irqQ   <= 1'b0;
    end else begin
      if (strobes.wrCtrl) ctrlQ <= regWdata;
      causeQ <= causeNext;
      maskQ  <= maskNext;
      irqQ   <= |(causeNext & ~maskNext);
    end
  end

  always_comb begin
    regRdata = '0;
    if (strobes.rdEn) begin
      case (strobes.rdSel)
        WORD_CTRL:   regRdata = ctrlQ;
        WORD_CAUSE:  regRdata = causeQ;
        WORD_MASKED: regRdata = causeQ & ~maskQ;
        WORD_MASK:   regRdata = maskQ;
        default:     regRdata = '0;
      endcase
    end
  end

  assign irqOut = irqQ;

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((causeQ & $past(setVec)) == $past(setVec))); // R5

  AST_MASK_SET_APPLIES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrMaskSet |=> ((maskQ & $past(regWdata)) == $past(regWdata))); // R7

  AST_MASK_CLR_APPLIES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrMaskClr |=> ((maskQ & $past(regWdata)) == '0)); // R7

  AST_READ_KEEPS_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdCause && !strobes.clrCause && !strobes.clrMasked) |=>
      ((causeQ & $past(causeQ & ~ctrlQ)) == $past(causeQ & ~ctrlQ))); // R4

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> (irqOut == |(causeQ & ~maskQ))); // R9

  AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdSel inside {WORD_FORCE, WORD_MASK_SET, WORD_MASK_CLR, WORD_SPARE})
      |-> (regRdata == '0)); // R10

endmodule

// File: rtl/irq_bank_top.sv
module irq_bank_top
  import irq_bank_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [WORD_ADDR_W-1:0] regAddr,
  input  logic                   regWe,
  input  logic [DATA_W-1:0]      regWdata,
  input  logic                   regRe,
  output logic [DATA_W-1:0]      regRdata,
  input  logic [DATA_W-1:0]      evtIn,
  output logic                   irqOut
);

  bankStrobes_t strobes;

  irq_bank_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWe   (regWe),
    .regRe   (regRe),
    .strobes (strobes)
  );

  irq_bank_dp #(.DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regWdata (regWdata),
    .evtIn    (evtIn),
    .regRdata (regRdata),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/irq_bank_top_tb_top.sv
module irq_bank_top_tb_top;

  localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
  localparam int NVEC = 24;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] evt;
    logic [31:0] expRd;
    logic        expIrq;
    logic [7:0]  req;
  } vec_t;

  // Words: 0 ctrl, 1 cause, 2 masked, 3 force, 4 mask, 5 mask-set, 6 mask-clr
  localparam vec_t VEC [NVEC] = '{
    '{OP_RD,   3'd1, 32'h0,   32'h0, 32'h0,   1'b0, 8'd1},  // R1 cause empty
    '{OP_IDLE, 3'd0, 32'h0,   32'h5, 32'h0,   1'b1, 8'd2},  // R2 events latch
    '{OP_RD,   3'd1, 32'h0,   32'h0, 32'h5,   1'b1, 8'd2},  // R2
    '{OP_WR,   3'd1, 32'h1,   32'h0, 32'h0,   1'b1, 8'd3},  // R3 w1c bit0
    '{OP_RD,   3'd1, 32'h0,   32'h0, 32'h4,   1'b1, 8'd3},  // R3
    '{OP_WR,   3'd4, 32'h4,   32'h0, 32'h0,   1'b0, 8'd7},  // R7 mask bit2
    '{OP_RD,   3'd2, 32'h0,   32'h0, 32'h0,   1'b0, 8'd8},  // R8 masked view
    '{OP_RD,   3'd4, 32'h0,   32'h0, 32'h4,   1'b0, 8'd7},  // R7 mask readback
    '{OP_WR,   3'd6, 32'h4,   32'h0, 32'h0,   1'b1, 8'd7},  // R7 mask-clr alias
    '{OP_WR,   3'd5, 32'hF0,  32'h0, 32'h0,   1'b1, 8'd7},  // R7 mask-set alias
    '{OP_RD,   3'd4, 32'h0,   32'h0, 32'hF0,  1'b1, 8'd7},  // R7
    '{OP_WR,   3'd1, 32'h4,   32'h0, 32'h0,   1'b0, 8'd9},  // R9 irq drops
    '{OP_WR,   3'd0, 32'h300, 32'h0, 32'h0,   1'b0, 8'd4},  // R4 bits 8,9 COR
    '{OP_RD,   3'd0, 32'h0,   32'h0, 32'h300, 1'b0, 8'd4},  // R4
    '{OP_WR,   3'd3, 32'h301, 32'h0, 32'h0,   1'b1, 8'd6},  // R6 force
    '{OP_RD,   3'd3, 32'h0,   32'h0, 32'h0,   1'b1, 8'd10}, // R10 wo reads 0
    '{OP_WR,   3'd1, 32'h301, 32'h0, 32'h0,   1'b1, 8'd3},  // R3 COR ignore write
    '{OP_RD,   3'd1, 32'h0,   32'h0, 32'h300, 1'b0, 8'd4},  // R4 read clears
    '{OP_RD,   3'd1, 32'h0,   32'h0, 32'h0,   1'b0, 8'd4},  // R4
    '{OP_WR,   3'd4, 32'h100, 32'h0, 32'h0,   1'b0, 8'd7},  // R7
    '{OP_WR,   3'd3, 32'h300, 32'h0, 32'h0,   1'b1, 8'd6},  // R6
    '{OP_RD,   3'd2, 32'h0,   32'h0, 32'h200, 1'b0, 8'd4},  // R4 masked read
    '{OP_RD,   3'd1, 32'h0,   32'h0, 32'h100, 1'b0, 8'd4},  // R4 masked bit kept
    '{OP_RD,   3'd1, 32'h0,   32'h0, 32'h0,   1'b0, 8'd4}   // R4
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic        regRe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] evtIn = '0;
  logic [31:0] regRdata;
  logic        irqOut;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  irq_bank_top dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRe(regRe), .regRdata(regRdata),
    .evtIn(evtIn), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [2:0] addr, input logic [31:0] wd,
                      input logic [31:0] ev, input logic [31:0] expRd, input logic expIrq,
                      input string tag);
    @(negedge clk);
    regAddr = addr; regWe = (op == OP_WR); regRe = (op == OP_RD);
    regWdata = wd; evtIn = ev;
    #1;
    if (op == OP_RD) check({tag, " rdata"}, regRdata, expRd);
    @(posedge clk);
    #2;
    check({tag, " irq"}, {31'b0, irqOut}, {31'b0, expIrq});
    regWe = 1'b0; regRe = 1'b0; evtIn = '0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 irq after reset", {31'b0, irqOut}, 32'h0);
    step(OP_RD, 3'd0, 0, 0, 32'h0, 1'b0, "R1 ctrl");
    step(OP_RD, 3'd4, 0, 0, 32'h0, 1'b0, "R1 mask");

    for (int i = 0; i < NVEC; i++)
      step(VEC[i].op, VEC[i].addr, VEC[i].wdata, VEC[i].evt, VEC[i].expRd, VEC[i].expIrq,
           $sformatf("R%0d vec%0d", VEC[i].req, i));

    // R5: clear-on-read of bit 8 (masked) while its event is high
    step(OP_WR, 3'd3, 32'h100, 0, 0, 1'b0, "R6 force bit8");
    step(OP_RD, 3'd1, 0, 32'h100, 32'h100, 1'b0, "R5 read with event");
    step(OP_RD, 3'd1, 0, 0, 32'h100, 1'b0, "R5 bit survives read");
    step(OP_RD, 3'd1, 0, 0, 32'h0, 1'b0, "R5 then cleared");

    // R5: write-one-to-clear of bit 0 while its event is high
    step(OP_WR, 3'd3, 32'h1, 0, 0, 1'b1, "R6 force bit0");
    step(OP_WR, 3'd1, 32'h1, 32'h1, 0, 1'b1, "R5 w1c with event");
    step(OP_RD, 3'd1, 0, 0, 32'h1, 1'b1, "R5 bit0 kept");
    step(OP_WR, 3'd1, 32'h1, 0, 0, 1'b0, "R3 w1c clears");

    // R10: no read enable gives zero; spare and alias words read zero
    step(OP_WR, 3'd3, 32'h2, 0, 0, 1'b1, "R6 force bit1");
    @(negedge clk);
    regAddr = 3'd1; regRe = 1'b0;
    #1;
    check("R10 rdata without re", regRdata, 32'h0);
    step(OP_RD, 3'd7, 0, 0, 32'h0, 1'b1, "R10 spare word");
    step(OP_RD, 3'd5, 0, 0, 32'h0, 1'b1, "R10 mask-set word");
    step(OP_RD, 3'd6, 0, 0, 32'h0, 1'b1, "R10 mask-clr word");
    step(OP_RD, 3'd2, 0, 0, 32'h2, 1'b1, "R8 masked shows bit1");

    // R1: reset in mid-run restores zero state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 irq after mid reset", {31'b0, irqOut}, 32'h0);
    step(OP_RD, 3'd0, 0, 0, 32'h0, 1'b0, "R1 ctrl cleared");
    step(OP_RD, 3'd1, 0, 0, 32'h0, 1'b0, "R1 cause cleared");
    step(OP_RD, 3'd4, 0, 0, 32'h0, 1'b0, "R1 mask cleared");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule